// File: doc/BRIEF.md
# Configurable DRAM Address Mapper

The mapper turns a physical byte address into the row, column, internal bank and chip-select values for one 64-bit SDRAM channel with ECC. Software sets every field of the split: where the row field starts, where the upper column bits come from, a contiguous mask that picks the bank bits, whether chip selects come from address ranges or from two interleave bits, a flag for devices with a fourteenth row pin, and a mode for FCRAM devices.

A request enters through a valid/ready handshake and is presented one cycle later as a registered command address. The row and column vectors are given as pin vectors. Bit n of each vector is the value on address pin n. In FCRAM mode, positions 13 and 14 of the row vector are the row bits that travel on the write-enable and column-strobe pins. Configuration is taken from the inputs only while no result is pending. While a result is held, the mapper keeps using the values it last took.

Top module: `dram_addr_map`

## Requirements
- R1: After reset, out_valid_o is 0, cs_no is 4'hF and in_ready_o is 1.
- R2: An accepted request appears on the outputs after exactly one clock edge. in_ready_o equals !out_valid_o || out_ready_i. While out_valid_o is 1 and out_ready_i is 0, every output holds its value.
- R3: Column pins A1 and A0 are always 0 and A10 is always 0. Column bit k sits on pin k for k below 10, and on pin k+1 for k of 10 or 11. Column bits 0 and 1 are 0. The total column width is cfg_col_bits_i, from 4 to 12. When cfg_col_lo_i is 1, column bits 3:2 are address bits 6:5 and the higher column bits start at address bit cfg_col_hi_lsb_i. When it is 0, all column bits from 2 upward start at that address bit.
- R4: Row bit i is address bit cfg_row_lsb_i+i. The row width is 15 in FCRAM mode, otherwise 14 when cfg_a13_i is 1, otherwise 13. Row pins above the width are 0, and so are address bits beyond bit 39.
- R5: Bank bits are the address bits marked in cfg_bank_mask_i. Mask bit j selects address bit j+5. The lowest marked bit is BA0, and the next ones follow in ascending order.
- R6: With three bank bits marked, the row width shrinks by one. The top pin of the unshrunk row width carries BA2 in both the row and column vectors. That pin is 12 for SDRAM with cfg_a13_i clear, 13 with it set, and 14 in FCRAM mode.
- R7: In interleave mode (cfg_cs_ilv_i = 1), the chip select numbered by address bits [lsb+1:lsb] is driven low and the other three stay high. Here lsb is cfg_cs_ilv_lsb_i.
- R8: In range mode, chip select g matches when base_g <= address[39:20] <= limit_g. The base and limit of g are bits [20g+19:20g] of cfg_cs_base_i and cfg_cs_limit_i. The lowest matching index is the only one driven low.
- R9: In range mode with no match, cs_no is 4'hF and oor_o is 1. In every other case oor_o is 0.
- R10: cfg_err_o is 1 when the bank mask is not contiguous, marks a number of bits other than 2 or 3, or overlaps the row field or the column bits taken from the address.
- R11: A configuration change made while a result is pending does not affect that result. It also does not affect a request accepted in the same cycle that the pending result is taken.
- R12: Address bits 2:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be taken |
| in_addr_i | input | 40 | Physical byte address |
| out_valid_o | output | 1 | Mapped result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| row_o | output | 15 | Row pin vector |
| col_o | output | 15 | Column pin vector |
| ba_o | output | 3 | Bank bits |
| cs_no | output | 4 | Chip selects, active low |
| oor_o | output | 1 | No chip-select range matched |
| cfg_err_o | output | 1 | Bank mask illegal for this configuration |
| cfg_row_lsb_i | input | 6 | Address bit of row bit 0 |
| cfg_a13_i | input | 1 | Devices have a fourteenth row pin |
| cfg_fcram_i | input | 1 | FCRAM mode, 15-bit row |
| cfg_col_bits_i | input | 4 | Total column width, 4 to 12 |
| cfg_col_lo_i | input | 1 | Column bits 3:2 come from address bits 6:5 |
| cfg_col_hi_lsb_i | input | 5 | Address bit of the first upper column bit |
| cfg_bank_mask_i | input | 32 | Bank mask over address bits 36:5 |
| cfg_cs_ilv_i | input | 1 | 1 selects interleave mode, 0 selects range mode |
| cfg_cs_ilv_lsb_i | input | 6 | Low address bit of the interleave pair |
| cfg_cs_base_i | input | 80 | Four range bases on address[39:20] |
| cfg_cs_limit_i | input | 80 | Four range limits on address[39:20] |

## Verification
Two things can happen in the same cycle: a configuration write and the hand-over of a held result to a newly accepted request. The bench provokes this by stalling the consumer on a mapped result, reprogramming every field, and presenting a second address. It then releases the consumer so that the old result leaves and the new request enters on the same edge. It judges the outcome in three steps. The held outputs must not move while the consumer is stalled. The second result must match the old configuration. Only a request issued after an idle cycle may follow the new settings.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;
  localparam int ADDR_W    = 40;
  localparam int ROW_PINS  = 15;
  localparam int COL_MAX   = 12;
  localparam int BANK_LSB  = 5;
  localparam int BANK_SPAN = 32;
  localparam int NUM_CS    = 4;
  localparam int RANGE_LSB = 20;
  localparam int RANGE_W   = ADDR_W - RANGE_LSB;
  localparam int CS_SEL_W  = $clog2(NUM_CS);

  typedef struct packed {
    logic [5:0]                 row_lsb;
    logic                       a13;
    logic                       fcram;
    logic [3:0]                 col_bits;
    logic                       col_lo;
    logic [4:0]                 col_hi_lsb;
    logic [BANK_SPAN-1:0]       bank_mask;
    logic                       cs_ilv;
    logic [5:0]                 cs_ilv_lsb;
    logic [NUM_CS*RANGE_W-1:0]  cs_base;
    logic [NUM_CS*RANGE_W-1:0]  cs_limit;
  } map_cfg_t;
endpackage

// File: rtl/dram_bank_map.sv
module dram_bank_map
  import dram_map_pkg::*;
(
  input  logic [BANK_SPAN-1:0] field_i,
  input  logic [BANK_SPAN-1:0] mask_i,
  output logic [2:0]           ba_o,
  output logic                 bank3_o,
  output logic                 bad_o,
  output logic [ADDR_W-1:0]    abs_mask_o
);
  logic [BANK_SPAN-1:0] lowest;
  logic                 contig;
  logic [5:0]           cnt;

  always_comb begin
    logic [2:0] k;
    k    = '0;
    ba_o = '0;
    for (int i = 0; i < BANK_SPAN; i++) begin
      if (mask_i[i] && k != 3'd3) begin
        ba_o[k[1:0]] = field_i[i];
        k = k + 3'd1;
      end
    end
  end

  assign lowest     = mask_i & (~mask_i + 1'b1);
  assign contig     = (|mask_i) && (((mask_i + lowest) & mask_i) == '0);
  assign cnt        = 6'($countones(mask_i));
  assign bank3_o    = (cnt == 6'd3);
  assign bad_o      = !contig || !((cnt == 6'd2) || (cnt == 6'd3));
  assign abs_mask_o = {{(ADDR_W-BANK_SPAN-BANK_LSB){1'b0}}, mask_i, {BANK_LSB{1'b0}}};
endmodule

// File: rtl/dram_row_map.sv
module dram_row_map
  import dram_map_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [5:0]          row_lsb_i,
  input  logic [4:0]          base_w_i,
  input  logic [3:0]          top_pin_i,
  input  logic                bank3_i,
  input  logic                ba2_i,
  output logic [ROW_PINS-1:0] row_o,
  output logic [ADDR_W-1:0]   row_mask_o
);
  logic [4:0]          w;
  logic [ROW_PINS-1:0] wmask;

  assign w     = bank3_i ? base_w_i - 5'd1 : base_w_i;
  assign wmask = ROW_PINS'((16'd1 << w) - 16'd1);

  always_comb begin
    row_o = ROW_PINS'(addr_i >> row_lsb_i) & wmask;
    if (bank3_i) row_o[top_pin_i] = ba2_i;
  end

  assign row_mask_o = {{(ADDR_W-ROW_PINS){1'b0}}, wmask} << row_lsb_i;
endmodule

// File: rtl/dram_col_map.sv
module dram_col_map
  import dram_map_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [3:0]          col_bits_i,
  input  logic                col_lo_i,
  input  logic [4:0]          hi_lsb_i,
  input  logic [3:0]          top_pin_i,
  input  logic                bank3_i,
  input  logic                ba2_i,
  output logic [ROW_PINS-1:0] col_o,
  output logic [ADDR_W-1:0]   col_mask_o
);
  logic [3:0]         hi_w;
  logic [COL_MAX-1:0] hi_mask, hi, colv;

  assign hi_w    = col_lo_i ? col_bits_i - 4'd4 : col_bits_i - 4'd2;
  assign hi_mask = COL_MAX'((13'd1 << hi_w) - 13'd1);
  assign hi      = COL_MAX'(addr_i >> hi_lsb_i) & hi_mask;
  // burst beat bits [1:0] always driven zero
  assign colv    = col_lo_i ? {hi[7:0], addr_i[6:5], 2'b00} : {hi[9:0], 2'b00};

  always_comb begin
    col_o = {2'b00, colv[11:10], 1'b0, colv[9:0]};  // A10 kept clear
    if (bank3_i) col_o[top_pin_i] = ba2_i;
  end

  assign col_mask_o = ({{(ADDR_W-COL_MAX){1'b0}}, hi_mask} << hi_lsb_i)
                    | (col_lo_i ? ADDR_W'(40'h60) : '0);
endmodule

// File: rtl/dram_cs_sel.sv
module dram_cs_sel
  import dram_map_pkg::*;
(
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      ilv_i,
  input  logic [5:0]                ilv_lsb_i,
  input  logic [NUM_CS*RANGE_W-1:0] base_i,
  input  logic [NUM_CS*RANGE_W-1:0] limit_i,
  output logic [NUM_CS-1:0]         cs_no,
  output logic                      oor_o
);
  logic [RANGE_W-1:0]  a_hi;
  logic [NUM_CS-1:0]   hit;
  logic [CS_SEL_W-1:0] sel;

  assign a_hi = addr_i[ADDR_W-1:RANGE_LSB];
  assign sel  = CS_SEL_W'(addr_i >> ilv_lsb_i);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_range
    assign hit[g] = (a_hi >= base_i[g*RANGE_W +: RANGE_W]) &&
                    (a_hi <= limit_i[g*RANGE_W +: RANGE_W]);
  end

  always_comb begin
    cs_no = '1;
    oor_o = 1'b0;
    if (ilv_i) begin
      cs_no[sel] = 1'b0;
    end else begin
      oor_o = 1'b1;
      for (int i = NUM_CS-1; i >= 0; i--) begin  // lowest index wins
        if (hit[i]) begin
          cs_no    = '1;
          cs_no[i] = 1'b0;
          oor_o    = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dram_addr_map.sv
module dram_addr_map
  import dram_map_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [ADDR_W-1:0]         in_addr_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [ROW_PINS-1:0]       row_o,
  output logic [ROW_PINS-1:0]       col_o,
  output logic [2:0]                ba_o,
  output logic [NUM_CS-1:0]         cs_no,
  output logic                      oor_o,
  output logic                      cfg_err_o,
  input  logic [5:0]                cfg_row_lsb_i,
  input  logic                      cfg_a13_i,
  input  logic                      cfg_fcram_i,
  input  logic [3:0]                cfg_col_bits_i,
  input  logic                      cfg_col_lo_i,
  input  logic [4:0]                cfg_col_hi_lsb_i,
  input  logic [BANK_SPAN-1:0]      cfg_bank_mask_i,
  input  logic                      cfg_cs_ilv_i,
  input  logic [5:0]                cfg_cs_ilv_lsb_i,
  input  logic [NUM_CS*RANGE_W-1:0] cfg_cs_base_i,
  input  logic [NUM_CS*RANGE_W-1:0] cfg_cs_limit_i
);
  map_cfg_t cfg_in, cfg_q, cfg;
  logic     out_valid_q, take;

  assign cfg_in = '{row_lsb: cfg_row_lsb_i, a13: cfg_a13_i, fcram: cfg_fcram_i,
                    col_bits: cfg_col_bits_i, col_lo: cfg_col_lo_i,
                    col_hi_lsb: cfg_col_hi_lsb_i, bank_mask: cfg_bank_mask_i,
                    cs_ilv: cfg_cs_ilv_i, cs_ilv_lsb: cfg_cs_ilv_lsb_i,
                    cs_base: cfg_cs_base_i, cs_limit: cfg_cs_limit_i};
  // live config only while idle, frozen while a result is pending
  assign cfg = out_valid_q ? cfg_q : cfg_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg;
  end

  logic [4:0]          base_w;
  logic [3:0]          top_pin;
  logic [2:0]          ba_d;
  logic                bank3, bank_bad;
  logic [ADDR_W-1:0]   bank_mask_abs, row_mask, col_mask;
  logic [ROW_PINS-1:0] row_d, col_d;
  logic [NUM_CS-1:0]   cs_d;
  logic                oor_d, err_d;

  assign base_w  = cfg.fcram ? 5'd15 : (cfg.a13 ? 5'd14 : 5'd13);
  assign top_pin = 4'(base_w - 5'd1);

  dram_bank_map u_bank (
    .field_i   (in_addr_i[BANK_LSB+BANK_SPAN-1:BANK_LSB]),
    .mask_i    (cfg.bank_mask),
    .ba_o      (ba_d),
    .bank3_o   (bank3),
    .bad_o     (bank_bad),
    .abs_mask_o(bank_mask_abs)
  );

  dram_row_map u_row (
    .addr_i    (in_addr_i),
    .row_lsb_i (cfg.row_lsb),
    .base_w_i  (base_w),
    .top_pin_i (top_pin),
    .bank3_i   (bank3),
    .ba2_i     (ba_d[2]),
    .row_o     (row_d),
    .row_mask_o(row_mask)
  );

  dram_col_map u_col (
    .addr_i    (in_addr_i),
    .col_bits_i(cfg.col_bits),
    .col_lo_i  (cfg.col_lo),
    .hi_lsb_i  (cfg.col_hi_lsb),
    .top_pin_i (top_pin),
    .bank3_i   (bank3),
    .ba2_i     (ba_d[2]),
    .col_o     (col_d),
    .col_mask_o(col_mask)
  );

  dram_cs_sel u_cs (
    .addr_i   (in_addr_i),
    .ilv_i    (cfg.cs_ilv),
    .ilv_lsb_i(cfg.cs_ilv_lsb),
    .base_i   (cfg.cs_base),
    .limit_i  (cfg.cs_limit),
    .cs_no    (cs_d),
    .oor_o    (oor_d)
  );

  assign err_d      = bank_bad || |(bank_mask_abs & (row_mask | col_mask));
  assign in_ready_o = !out_valid_q || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      row_o       <= '0;
      col_o       <= '0;
      ba_o        <= '0;
      cs_no       <= '1;
      oor_o       <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else if (take) begin
      out_valid_q <= 1'b1;
      row_o       <= row_d;
      col_o       <= col_d;
      ba_o        <= ba_d;
      cs_no       <= cs_d;
      oor_o       <= oor_d;
      cfg_err_o   <= err_d;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
endmodule

// File: rtl/dram_addr_map_chk.sv
module dram_addr_map_chk
  import dram_map_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic [ROW_PINS-1:0] row_o,
  input logic [ROW_PINS-1:0] col_o,
  input logic [2:0]          ba_o,
  input logic [NUM_CS-1:0]   cs_no,
  input logic                oor_o,
  input logic                cfg_err_o
);
  logic [ROW_PINS*2+3+NUM_CS+1:0] bundle;
  assign bundle = {row_o, col_o, ba_o, cs_no, oor_o, cfg_err_o};

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(bundle));

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  assert_col_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (col_o[10] == 1'b0) && (col_o[1:0] == 2'b00));

  assert_single_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones(~cs_no) <= 1);

  assert_oor_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && oor_o |-> cs_no == '1);

  assert_one_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !oor_o |-> $countones(~cs_no) == 1);
endmodule

bind dram_addr_map dram_addr_map_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .row_o      (row_o),
  .col_o      (col_o),
  .ba_o       (ba_o),
  .cs_no      (cs_no),
  .oor_o      (oor_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/dram_addr_map_bench.sv
`timescale 1ns/1ps
module dram_addr_map_bench;
  import dram_map_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        out_ready_i = 1'b1;
  logic [39:0] in_addr_i = '0;
  logic        in_ready_o, out_valid_o, oor_o, cfg_err_o;
  logic [14:0] row_o, col_o;
  logic [2:0]  ba_o;
  logic [3:0]  cs_no;
  map_cfg_t    c = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk_i = ~clk_i;

  dram_addr_map u_dram_addr_map (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_addr_i(in_addr_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .row_o(row_o), .col_o(col_o), .ba_o(ba_o), .cs_no(cs_no), .oor_o(oor_o),
    .cfg_err_o(cfg_err_o), .cfg_row_lsb_i(c.row_lsb), .cfg_a13_i(c.a13),
    .cfg_fcram_i(c.fcram), .cfg_col_bits_i(c.col_bits), .cfg_col_lo_i(c.col_lo),
    .cfg_col_hi_lsb_i(c.col_hi_lsb), .cfg_bank_mask_i(c.bank_mask),
    .cfg_cs_ilv_i(c.cs_ilv), .cfg_cs_ilv_lsb_i(c.cs_ilv_lsb),
    .cfg_cs_base_i(c.cs_base), .cfg_cs_limit_i(c.cs_limit)
  );

  function automatic logic [38:0] model(map_cfg_t k, logic [39:0] a);
    logic [14:0] r, cp;
    logic [2:0]  ba;
    logic [3:0]  cs;
    logic        oor, err, v;
    logic [39:0] rm, cm, bm;
    int nb, first, last, rw, ue, hb, idx, pin, sel;
    r = '0; cp = '0; ba = '0; rm = '0; cm = '0; bm = '0;
    nb = 0; first = -1; last = -1;
    for (int i = 0; i < 32; i++) if (k.bank_mask[i]) begin
      bm[i+5] = 1'b1;
      if (nb < 3) ba[nb] = a[i+5];
      nb++;
      if (first < 0) first = i;
      last = i;
    end
    rw = k.fcram ? 15 : (k.a13 ? 14 : 13);
    ue = (nb == 3) ? rw - 1 : rw;
    for (int i = 0; i < ue; i++) begin
      idx = k.row_lsb + i;
      if (idx < 40) begin r[i] = a[idx]; rm[idx] = 1'b1; end
    end
    if (nb == 3) r[rw-1] = ba[2];
    hb = 0;
    for (int kk = 2; kk < k.col_bits && kk < 12; kk++) begin
      if (k.col_lo && kk < 4) begin
        v = a[kk+3]; cm[kk+3] = 1'b1;
      end else begin
        idx = k.col_hi_lsb + hb; v = a[idx]; cm[idx] = 1'b1; hb++;
      end
      pin = (kk < 10) ? kk : kk + 1;
      cp[pin] = v;
    end
    if (nb == 3) cp[rw-1] = ba[2];
    err = !(nb == 2 || nb == 3) || (last - first + 1 != nb) || |(bm & (rm | cm));
    cs = 4'hF; oor = 1'b0;
    if (k.cs_ilv) begin
      sel = {a[k.cs_ilv_lsb+1], a[k.cs_ilv_lsb]};
      cs[sel] = 1'b0;
    end else begin
      oor = 1'b1;
      for (int g = 0; g < 4; g++)
        if (oor && a[39:20] >= k.cs_base[g*20 +: 20] && a[39:20] <= k.cs_limit[g*20 +: 20]) begin
          cs[g] = 1'b0; oor = 1'b0;
        end
    end
    return {r, cp, ba, cs, oor, err};
  endfunction

  function automatic logic [39:0] got();
    return {out_valid_o, row_o, col_o, ba_o, cs_no, oor_o, cfg_err_o};
  endfunction

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(string tag, logic [39:0] a);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_addr_i = a;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(tag, got(), {1'b1, model(c, a)});
  endtask

  task automatic base_cfg();
    c = '0;
    c.row_lsb = 6'd15; c.col_bits = 4'd10; c.col_lo = 1'b1; c.col_hi_lsb = 5'd7;
    c.bank_mask = 32'h300; c.cs_ilv = 1'b1; c.cs_ilv_lsb = 6'd28;
  endtask

  task automatic t_reset();
    check("R1 reset state", {38'd0, in_ready_o, out_valid_o, cs_no}, {38'd0, 1'b1, 1'b0, 4'hF});
  endtask

  task automatic t_basic();
    base_cfg();
    xfer("R3 R4 R5 R7 zero", 40'h00_0000_0000);
    xfer("R3 R4 R5 R7 ones", 40'hFF_FFFF_FFF8);
    xfer("R4 R5 R7 pattern", 40'h12_3456_7890);
    xfer("R3 R7 pattern2",   40'h0A_5A5A_5A58);
  endtask

  task automatic t_wide();
    base_cfg();
    c.a13 = 1'b1; c.col_bits = 4'd12; c.col_lo = 1'b0; c.col_hi_lsb = 5'd7;
    c.bank_mask = 32'h3000; c.row_lsb = 6'd19; c.cs_ilv_lsb = 6'd33;
    xfer("R3 R4 wide col a", 40'h3C_F0F1_8E40);
    xfer("R3 R4 wide col b", 40'hC3_0F0E_71B8);
  endtask

  task automatic t_bank3();
    base_cfg();
    c.bank_mask = 32'h700; c.row_lsb = 6'd16;
    xfer("R6 bank3 pin12 ba2=1", 40'h00_0F0F_8000);
    xfer("R6 bank3 pin12 ba2=0", 40'h00_0FFF_7FF8);
    c.fcram = 1'b1;
    xfer("R6 fcram bank3 pin14", 40'h00_F0F0_8000);
    c.bank_mask = 32'h300; c.row_lsb = 6'd15;
    xfer("R4 fcram 15-bit row", 40'h00_7FFF_8000);
  endtask

  task automatic t_range();
    base_cfg();
    c.cs_ilv = 1'b0;
    c.cs_base  = {20'h80000, 20'h00080, 20'h00100, 20'h00000};
    c.cs_limit = {20'hFFFFF, 20'h00180, 20'h001FF, 20'h000FF};
    xfer("R8 range cs0",          40'h00_0500_0000);
    xfer("R8 overlap lowest wins", 40'h00_1500_0000);
    xfer("R8 limit edge cs0",     40'h00_0FF0_0000);
    xfer("R8 base edge cs1",      40'h00_1000_0000);
    xfer("R8 range cs3",          40'h90_0000_0000);
    xfer("R9 no match",           40'h00_2000_0000);
  endtask

  task automatic t_err();
    base_cfg();
    c.bank_mask = 32'h500;  xfer("R10 noncontig mask", 40'h00_1234_5678);
    c.bank_mask = 32'h100;  xfer("R10 single bank bit", 40'h00_1234_5678);
    c.bank_mask = 32'hC00;  xfer("R10 overlap row", 40'h00_1234_5678);
    c.bank_mask = 32'h3;    xfer("R10 overlap low col", 40'h00_1234_5678);
    c.bank_mask = 32'h300;  xfer("R10 legal mask", 40'h00_1234_5678);
  endtask

  task automatic t_low();
    logic [39:0] ref_out;
    base_cfg();
    xfer("R12 low bits 000", 40'h5A_A55A_A550);
    ref_out = got();
    xfer("R12 low bits 111", 40'h5A_A55A_A557);
    check("R12 same result", got(), ref_out);
  endtask

  task automatic t_hold();
    map_cfg_t old_c;
    logic [39:0] a_held, a_next, a_late, held;
    a_held = 40'h21_4365_8798; a_next = 40'h3F_00FF_0F08; a_late = 40'h07_7777_1110;
    base_cfg(); old_c = c;
    @(negedge clk_i);
    out_ready_i = 1'b0; in_valid_i = 1'b1; in_addr_i = a_held;
    @(negedge clk_i);
    in_addr_i = a_next;
    c.row_lsb = 6'd20; c.a13 = 1'b1; c.col_lo = 1'b0; c.col_hi_lsb = 5'd9;
    c.bank_mask = 32'h3; c.cs_ilv_lsb = 6'd36;
    held = {1'b1, model(old_c, a_held)};
    check("R2 first result", got(), held);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check("R2 held under backpressure", got(), held);
      check("R2 ready low while held", {39'd0, in_ready_o}, 40'd0);
    end
    out_ready_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R11 handover uses old config", got(), {1'b1, model(old_c, a_next)});
    xfer("R11 idle request uses new config", a_late);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_wide();
    t_bank3();
    t_range();
    t_err();
    t_low();
    t_hold();
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule